// File: doc/BRIEF.md
# Receive DMA Ready Generator

This block drives the active-low receive DMA request line of a UART receiver. It watches the fill count of the receive queue and the two FIFO control bits, and raises the request in one of two styles. In single-transfer style the line is low whenever any character waits. In burst style it goes low once the fill count reaches a programmable trigger level, or once a character time-out has expired. It then stays low until the queue is fully drained.

The character time-out is produced inside the block. A counter advances on a character-time tick while data waits unread. A newly received character, a read, or an empty queue restarts it. The queue storage, the serial receiver and the host bus sit outside the block. They supply the fill count and the push, pop and tick strobes.

Top module: `rx_dma_ready`

## Requirements
- R1: Burst style applies only when `fifo_en` is 1 and `dma_burst` is 1. With `fifo_en` at 0, `dma_burst` has no effect and single-transfer style applies.
- R2: In single-transfer style `rxrdy_n` is 0 in the same cycle that `fill` is non-zero, and 1 when `fill` is 0.
- R3: In burst style `rxrdy_n` goes 0 in the same cycle that `fill` is greater than or equal to `trig_lvl`, provided `fill` is non-zero.
- R4: In burst style, while `timeout` is 1 and `fill` is non-zero, `rxrdy_n` is 0 even when `fill` is below `trig_lvl`.
- R5: In burst style, once `rxrdy_n` is 0 it stays 0 while `fill` stays non-zero, even below the trigger. It is 1 in the same cycle that `fill` reads 0.
- R6: While `rst_n` is 0, `rxrdy_n` is 1 and `timeout` is 0. After reset, no request is held and the time-out count is zero.
- R7: With `fill` non-zero and no push or pop, `timeout` becomes 1 on the clock edge that takes the `char_tick` count since the last restart to `to_limit`. A `to_limit` of 0 acts as 1. It then stays 1.
- R8: A cycle with `rx_push` or `rx_pop` high clears `timeout` and restarts the count at the next edge. This takes priority over a `char_tick` in the same cycle.
- R9: While `fill` is 0 the count is held at zero and `timeout` is cleared at the next edge.
- R10: Any cycle in single-transfer style drops a held burst request. On return to burst style with `fill` below the trigger and no time-out, `rxrdy_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFO operation enable |
| dma_burst | input | 1 | DMA style select, 1 = burst (effective only with fifo_en) |
| trig_lvl | input | CNT_W | Fill level that raises a burst request |
| fill | input | CNT_W | Characters currently held in the receive queue |
| rx_push | input | 1 | A character was written into the queue this cycle |
| rx_pop | input | 1 | A character was read from the queue this cycle |
| char_tick | input | 1 | One pulse per character time |
| to_limit | input | TO_W | Character times of inactivity before time-out |
| rxrdy_n | output | 1 | Active-low receive DMA request |
| timeout | output | 1 | Character time-out is pending |

## Verification
Two events can land in the same cycle. A read can arrive on the very tick that would complete the time-out, and the trigger or time-out condition can be present in the same cycle that the fill count reaches zero. The bench forces both cases directly. It pulses `rx_pop` together with the final `char_tick`, and it drops `fill` to 0 while the count is above the trigger. In the first case `timeout` must remain 0. In the second, `rxrdy_n` must be 1 in that same cycle. A seeded random phase then mixes ticks, strobes, mode flips and fill changes. Every cycle is compared with a bench model of the requirements.

// File: rtl/rxdma_pkg.sv
// Shared types for the receive DMA ready generator.
// Assumes: none beyond the two-bit FIFO control decode.
package rxdma_pkg;

    typedef enum logic {
        DMA_SINGLE = 1'b0,
        DMA_BURST  = 1'b1
    } dma_style_e;

    // Burst style only when FIFO operation is on and the burst bit is set.
    function automatic dma_style_e pick_style(input logic fifo_on, input logic burst_bit);
        return (fifo_on && burst_bit) ? DMA_BURST : DMA_SINGLE;
    endfunction

endpackage

// File: rtl/rxdma_style_dec.sv
// Decodes the FIFO control bits into the DMA request style.
// Assumes: both control bits are stable register outputs.
module rxdma_style_dec
    import rxdma_pkg::*;
(
    input  logic       fifo_en,
    input  logic       dma_burst,
    output dma_style_e style
);

    // Purpose: select the request style.
    always_comb begin
        style = pick_style(fifo_en, dma_burst);
    end

endmodule

// File: rtl/rxdma_timeout.sv
// Character time-out counter. It counts char_tick pulses while data waits
// with no push or pop, and raises a sticky flag at the programmed limit.
// Assumes: char_tick is a one-cycle pulse; a limit of 0 behaves as 1.
module rxdma_timeout #(
    parameter int CNT_W = 7,
    parameter int TO_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    input  logic [TO_W-1:0]  to_limit,
    output logic             to_flag
);

    localparam int EXT_W = TO_W + 1;

    logic [TO_W-1:0]  tick_cnt;
    logic [EXT_W-1:0] cnt_next;
    logic [EXT_W-1:0] lim_eff;
    logic             restart;

    // Purpose: restart conditions, next count and effective limit.
    always_comb begin
        restart  = rx_push || rx_pop || (fill == '0);
        cnt_next = {1'b0, tick_cnt} + 1'b1;
        lim_eff  = (to_limit == '0) ? EXT_W'(1) : {1'b0, to_limit};
    end

    // Purpose: advance the count and set the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            to_flag  <= 1'b0;
        end else if (restart) begin
            tick_cnt <= '0;
            to_flag  <= 1'b0;
        end else if (char_tick && !to_flag) begin
            tick_cnt <= cnt_next[TO_W-1:0];
            if (cnt_next >= lim_eff) begin
                to_flag <= 1'b1;
            end
        end
    end

    // R8: a push or pop always clears the flag at the next edge
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> !to_flag);

    // R9: an empty queue clears the flag at the next edge
    a_r9_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |=> !to_flag);

    // R6: reset leaves no pending time-out
    a_r6_reset_flag: assert property (@(posedge clk)
        !rst_n |=> !to_flag);

    // R7: the flag can only rise on a tick with data and no strobe
    a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_flag && !(char_tick && !restart)) |=> !to_flag);

endmodule

// File: rtl/rxdma_req_gen.sv
// Request generator. It drives rxrdy_n in single-transfer or burst style
// and holds the burst request until the queue is empty.
// Assumes: to_flag comes from a registered time-out counter.
module rxdma_req_gen
    import rxdma_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dma_style_e       style,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic             to_flag,
    output logic             rxrdy_n
);

    logic has_data;
    logic burst_hit;
    logic held;
    logic armed;

    // Purpose: data and trigger conditions.
    always_comb begin
        has_data  = (fill != '0);
        burst_hit = held || (fill >= trig_lvl) || to_flag;
    end

    // Purpose: active-low request for the selected style.
    always_comb begin
        if (!rst_n || !has_data) begin
            rxrdy_n = 1'b1;
        end else if (style == DMA_SINGLE) begin
            rxrdy_n = 1'b0;
        end else begin
            rxrdy_n = !burst_hit;
        end
    end

    // Purpose: hold a burst request until the queue drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else begin
            held <= (style == DMA_BURST) && has_data && burst_hit;
        end
    end

    // Purpose: mark cycles with a reset-free history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    // R5: a burst request persists while data remains
    a_r5_hold_until_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && style == DMA_BURST && $past(style == DMA_BURST)
         && $past(!rxrdy_n) && fill != '0) |-> !rxrdy_n);

    // R5: an empty queue never requests
    a_r5_empty_idle: assert property (@(posedge clk)
        (fill == '0) |-> rxrdy_n);

    // R10: single style never leaves a held request
    a_r10_single_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (style == DMA_SINGLE) |=> !held);

    // R6: reset keeps the request inactive
    a_r6_reset_idle: assert property (@(posedge clk)
        !rst_n |-> rxrdy_n);

endmodule

// File: rtl/rx_dma_ready.sv
// Top of the receive DMA ready generator. It wires the style decode, the
// time-out counter and the request generator.
// Assumes: fill, push and pop come from the receive queue in the same clock.
module rx_dma_ready
    import rxdma_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TO_W  = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_burst,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic [CNT_W-1:0] fill,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    input  logic [TO_W-1:0]  to_limit,
    output logic             rxrdy_n,
    output logic             timeout
);

    dma_style_e style;
    logic       to_flag;

    rxdma_style_dec u_dec (
        .fifo_en   (fifo_en),
        .dma_burst (dma_burst),
        .style     (style)
    );

    rxdma_timeout #(.CNT_W(CNT_W), .TO_W(TO_W)) u_to (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill      (fill),
        .rx_push   (rx_push),
        .rx_pop    (rx_pop),
        .char_tick (char_tick),
        .to_limit  (to_limit),
        .to_flag   (to_flag)
    );

    rxdma_req_gen #(.CNT_W(CNT_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .style    (style),
        .fill     (fill),
        .trig_lvl (trig_lvl),
        .to_flag  (to_flag),
        .rxrdy_n  (rxrdy_n)
    );

    // Purpose: expose the pending time-out.
    always_comb begin
        timeout = to_flag;
    end

    // R1: without FIFO operation the style is always single-transfer
    a_r1_nonfifo_single: assert property (@(posedge clk)
        !fifo_en |-> (style == DMA_SINGLE));

endmodule

// File: tb/tb_rx_dma_ready.sv
// Self-checking bench: seeded random stimulus plus directed corner cases,
// compared each cycle against a requirement model.
module tb_rx_dma_ready;

    localparam int CNT_W = 7;
    localparam int TO_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_en = 1'b0;
    logic             dma_burst = 1'b0;
    logic [CNT_W-1:0] trig_lvl = '0;
    logic [CNT_W-1:0] fill = '0;
    logic             rx_push = 1'b0;
    logic             rx_pop = 1'b0;
    logic             char_tick = 1'b0;
    logic [TO_W-1:0]  to_limit = '0;
    logic             rxrdy_n;
    logic             timeout;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    bit m_flag = 1'b0;
    bit m_held = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_dma_ready #(.DEPTH(64), .TO_W(TO_W)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_burst(dma_burst),
        .trig_lvl(trig_lvl), .fill(fill), .rx_push(rx_push), .rx_pop(rx_pop),
        .char_tick(char_tick), .to_limit(to_limit),
        .rxrdy_n(rxrdy_n), .timeout(timeout)
    );

    function automatic bit exp_rdy_n();
        if (!rst_n || fill == 0) return 1'b1;
        if (!(fifo_en && dma_burst)) return 1'b0;
        return !(m_held || fill >= trig_lvl || m_flag);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Check outputs mid-cycle, then advance the model across the edge.
    task automatic cyc(input string tag);
        int lim;
        #1;
        check(tag, rxrdy_n, exp_rdy_n(), "rxrdy_n");
        check(tag, timeout, m_flag, "timeout");
        @(posedge clk);
        lim = (to_limit == 0) ? 1 : int'(to_limit);
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_held = 0;
        end else begin
            m_held = (fifo_en && dma_burst) && fill != 0 && (m_held || fill >= trig_lvl || m_flag);
            if (rx_push || rx_pop || fill == 0) begin
                m_cnt = 0; m_flag = 0;
            end else if (char_tick && !m_flag) begin
                m_cnt++;
                if (m_cnt >= lim) m_flag = 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle_strobes();
        rx_push = 0; rx_pop = 0; char_tick = 0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        @(negedge clk);
        // R6: reset forces the request inactive despite data
        rst_n = 0; fill = 5;
        cyc("R6"); cyc("R6");
        rst_n = 1; fill = 0;
        cyc("R6");

        // R1 R2: single style, including non-FIFO with the burst bit set
        fifo_en = 0; dma_burst = 1; trig_lvl = 8; to_limit = 3;
        fill = 1; rx_push = 1; cyc("R2"); rx_push = 0;
        fill = 3; cyc("R1");
        fill = 0; cyc("R2");
        fifo_en = 1; dma_burst = 0; fill = 2; cyc("R2");
        fill = 0; cyc("R2");

        // R3 R5: burst style trigger, hold, and same-cycle release
        dma_burst = 1;
        fill = 3; rx_push = 1; cyc("R3"); rx_push = 0;
        fill = 8; rx_push = 1; cyc("R3"); rx_push = 0;
        fill = 4; rx_pop = 1; cyc("R5"); rx_pop = 0;
        fill = 1; rx_pop = 1; cyc("R5");
        fill = 0; cyc("R5"); rx_pop = 0;
        cyc("R5");

        // R7 R4: time-out after three ticks raises the request
        fill = 2; rx_push = 1; cyc("R7"); rx_push = 0;
        char_tick = 1; cyc("R7"); cyc("R7"); char_tick = 0;
        cyc("R7");
        char_tick = 1; cyc("R7"); char_tick = 0;
        cyc("R4"); cyc("R4");

        // R5: trigger present while the fill count reaches zero
        fill = 20; cyc("R5");
        fill = 0; cyc("R5");
        cyc("R9");

        // R8: pop coincides with the completing tick
        fill = 2; rx_push = 1; cyc("R8"); rx_push = 0;
        char_tick = 1; cyc("R8"); cyc("R8");
        rx_pop = 1; cyc("R8"); rx_pop = 0; char_tick = 0;
        cyc("R8"); cyc("R8");

        // R10: held burst request dropped by a single-style cycle
        fill = 9; cyc("R10");
        fill = 3; cyc("R10");
        dma_burst = 0; cyc("R10");
        dma_burst = 1; cyc("R10");
        fill = 0; cyc("R9");

        // R9: zero limit acts as one; empty queue holds the count
        to_limit = 0; fill = 1; rx_push = 1; cyc("R7"); rx_push = 0;
        char_tick = 1; cyc("R7"); char_tick = 0;
        cyc("R4");
        fill = 0; cyc("R9"); cyc("R9");

        // Random phase over all requirements
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 2) fifo_en = ~fifo_en;
            if (r >= 2 && r < 5) dma_burst = ~dma_burst;
            if ($urandom_range(0, 199) == 0) trig_lvl = CNT_W'($urandom_range(1, 16));
            if ($urandom_range(0, 199) == 0) to_limit = TO_W'($urandom_range(0, 5));
            rst_n = ($urandom_range(0, 499) != 0);
            char_tick = ($urandom_range(0, 2) == 0);
            rx_push = 0; rx_pop = 0;
            r = $urandom_range(0, 19);
            if (r == 0 && fill < 64) begin rx_push = 1; fill = fill + 1; end
            else if (r == 1 && fill > 0) begin rx_pop = 1; fill = fill - 1; end
            else if (r == 2 && fill > 0) begin rx_pop = 1; fill = 0; end
            else if (r == 3) begin rx_push = 1; rx_pop = 1; end
            cyc((fifo_en && dma_burst) ? "R3" : "R2");
        end
        idle_strobes();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule